// File: doc/BRIEF.md
# Codec Host Register Interface

This block is the host-facing register unit of an audio codec. A host sees four byte-wide direct registers, selected by a two-bit address: a pointer register, a window onto the indirect register bank, an interrupt status register and a programmed-I/O data port. The host loads the pointer with the number of an indirect register. It then reads or writes that register through the window. The bank holds up to 32 eight-bit control registers. A mode bit decides whether the upper half of the bank can be reached.

Reads are combinational from the current state. A read that has a side effect, the calibration-busy countdown, takes that effect at the clock edge while the read strobe is high. The block drives the current playback format byte and interface configuration byte to the datapath. It also drives an interrupt line and a one-cycle strobe that marks the moment a pending interrupt is acknowledged. A single-cycle completion pulse from the playback engine raises the interrupt.

Top module: `codec_reg_if`

## Requirements
- R1: Address 3 is a data port that always reads 0x00, and writes to it change nothing. Address 2 reads the interrupt status, with INT at bit 0 and all other bits 0. Address 0 is the pointer and address 1 is the indirect window.
- R2: The pointer resets to 0x40. A write stores the byte with bit 7 cleared, so bit 7 always reads back as 0. Pointer bit 6 is the mode-change enable (MCE).
- R3: The indirect register number is pointer[3:0] while the extended-mode bit (bit 6 of register 12) is 0, and pointer[4:0] while it is 1.
- R4: After reset, registers 2, 3, 4, 5, 18 and 19 read 0x88, registers 6 and 7 read 0x80, register 9 reads 0x08, register 12 reads 0x8A, registers 25 and 26 read 0xA0, and every other register reads 0x00. After reset the interrupt line is low, the format output is 0x00 and the configuration output is 0x08.
- R5: A write to register 8, the format register, is stored in full while MCE is 1. If MCE is 0 and the partial-enable bit (bit 7 of register 24) is 1, only bits [7:4] take the written value and bits [3:0] keep their old value. If both bits are 0, the write is dropped.
- R6: Register 9, the interface configuration, always stores bit 5 as 0. Its value drives the configuration output.
- R7: Register 11 is read-only, and writes to it are discarded.
- R8: A write to register 12 copies only written bit 6 into bit 6. Its other bits keep their values.
- R9: Any write to address 2 clears INT and clears bits 4, 5 and 6 of register 24 (the playback, capture and timer flags). The interrupt line goes low. If INT was 1, the acknowledge strobe is high for one cycle after the write.
- R10: A write to register 24 that turns bit 4 from 1 to 0 clears INT and pulses the acknowledge strobe.
- R11: A playback completion pulse sets INT and bit 4 of register 24 on the next edge. If a clear happens in the same cycle, the set wins.
- R12: A pointer write that raises MCE from 0 to 1 while register 9 bits [4:3] are nonzero loads a calibration counter with 3. While the counter is nonzero, a read of register 11 returns 0x20 and decrements the counter. Otherwise register 11 reads 0x00. An MCE rise while register 9 bits [4:3] are both zero does not load the counter.
- R13: Registers 22, 27 and 29 are reserved. They read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Direct register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pb_done | input | 1 | Playback block-complete pulse |
| irq | output | 1 | Interrupt request (INT) |
| irq_ack | output | 1 | One-cycle interrupt acknowledge strobe |
| fmt_out | output | 8 | Current playback format register |
| cfg_out | output | 8 | Current interface configuration register |

## Verification
The completion pulse that sets the interrupt and a host write that clears it can land on the same clock edge. This can be a write to the status address or a write that drops the playback flag. The bench first raises the interrupt. It then drives the status-address write and the completion pulse in one cycle. It judges the outcome by checking that the line is still high and that the playback flag in register 24 reads back as set. A separate case checks that a clear with no completion pulse in the same cycle drops the line and produces the strobe.

// File: rtl/codec_reg_pkg.sv
// Package: shared constants, register numbers and reset values for the
// codec host register interface. Assumes an 8-bit bank of at most 32 entries.
package codec_reg_pkg;

    typedef enum logic [1:0] {
        DR_PTR    = 2'd0,
        DR_WINDOW = 2'd1,
        DR_STATUS = 2'd2,
        DR_PIO    = 2'd3
    } dreg_e;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned IX_FMT     = 8;
    localparam int unsigned IX_CFG     = 9;
    localparam int unsigned IX_ERRST   = 11;
    localparam int unsigned IX_MODE    = 12;
    localparam int unsigned IX_AFSTAT  = 24;

    localparam int unsigned PTR_MCE    = 6;
    localparam int unsigned MODE_EXT   = 6;
    localparam int unsigned CFG_RSV    = 5;
    localparam int unsigned ERR_CAL    = 5;
    localparam int unsigned AF_PI      = 4;
    localparam int unsigned AF_CI      = 5;
    localparam int unsigned AF_TI      = 6;
    localparam int unsigned AF_PMCE    = 7;

    localparam logic [7:0] PTR_RESET   = 8'h40;

    // Reset value of an indirect register.
    function automatic logic [7:0] ind_reset_val(input int idx);
        case (idx)
            2, 3, 4, 5, 18, 19: return 8'h88;
            6, 7:               return 8'h80;
            9:                  return 8'h08;
            12:                 return 8'h8A;
            25, 26:             return 8'hA0;
            default:            return 8'h00;
        endcase
    endfunction

    // Reserved indirect register numbers.
    function automatic logic is_reserved(input int idx);
        return (idx == 22) || (idx == 27) || (idx == 29);
    endfunction

endpackage

// File: rtl/codec_ptr_unit.sv
// Module: pointer register and calibration-busy counter.
// Holds the direct pointer (bit 7 always 0). When a pointer write raises MCE
// while calibration is enabled, loads a countdown that read accesses consume.
// Assumes a read and a write never occur in the same cycle.
module codec_ptr_unit
    import codec_reg_pkg::*;
#(
    parameter int unsigned CAL_LOAD = 3,
    localparam int unsigned CAL_W   = $clog2(CAL_LOAD + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_wr,
    input  logic [7:0] wdata,
    input  logic       cal_en,
    input  logic       cal_take,
    output logic [7:0] ptr_q,
    output logic       cal_busy
);

    logic [CAL_W-1:0] cal_cnt_q;
    logic             mce_rise;

    // Detect the 0->1 MCE transition carried by this write.
    always_comb begin
        mce_rise = ptr_wr && !ptr_q[PTR_MCE] && wdata[PTR_MCE];
    end

    // Pointer storage with bit 7 forced low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_RESET;
        end else if (ptr_wr) begin
            ptr_q <= {1'b0, wdata[6:0]};
        end
    end

    // Calibration countdown: load on enabled MCE rise, count down on reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_cnt_q <= '0;
        end else if (mce_rise && cal_en) begin
            cal_cnt_q <= CAL_W'(CAL_LOAD);
        end else if (cal_take && (cal_cnt_q != '0)) begin
            cal_cnt_q <= cal_cnt_q - 1'b1;
        end
    end

    assign cal_busy = (cal_cnt_q != '0);

endmodule

// File: rtl/codec_ind_bank.sv
// Module: indirect control register bank.
// One byte register per index, each built from a generate variant that
// applies its own write rule (full, gated format, masked, mode-bit only,
// flag register, read-only, reserved). Assumes at most one access per cycle.
module codec_ind_bank
    import codec_reg_pkg::*;
#(
    parameter int unsigned REG_N  = 32,
    localparam int unsigned IDX_W = $clog2(REG_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic             mce,
    input  logic             cal_busy,
    input  logic             set_pi,
    input  logic             clr_flags,
    output logic [7:0]       rd_val,
    output logic [7:0]       fmt_q,
    output logic [7:0]       cfg_q,
    output logic             ext_mode,
    output logic             pmce,
    output logic             pi_fall
);

    logic [REG_N*REG_W-1:0] bank_flat;
    logic [7:0]             afstat_w;

    genvar g;
    generate
        for (g = 0; g < REG_N; g++) begin : g_reg
            logic [7:0] r_q;
            logic [7:0] r_d;
            logic       hit;

            assign hit = win_wr && (idx == IDX_W'(g));

            if (is_reserved(g) || (g == IX_ERRST)) begin : g_const
                // Reserved and read-only entries keep their reset value.
                always_comb r_d = r_q;
            end else if (g == IX_FMT) begin : g_fmt
                // Format writes gated by MCE (full) or PMCE (upper nibble).
                always_comb begin
                    r_d = r_q;
                    if (hit && mce)
                        r_d = wdata;
                    else if (hit && pmce)
                        r_d = {wdata[7:4], r_q[3:0]};
                end
            end else if (g == IX_CFG) begin : g_cfg
                // Configuration stores bit 5 as zero.
                always_comb begin
                    r_d = r_q;
                    if (hit) begin
                        r_d = wdata;
                        r_d[CFG_RSV] = 1'b0;
                    end
                end
            end else if (g == IX_MODE) begin : g_mode
                // Mode register: only the extended-mode bit is writable.
                always_comb begin
                    r_d = r_q;
                    if (hit) r_d[MODE_EXT] = wdata[MODE_EXT];
                end
            end else if (g == IX_AFSTAT) begin : g_afs
                // Flag register: write, then status clear, then set wins.
                always_comb begin
                    r_d = r_q;
                    if (hit) r_d = wdata;
                    if (clr_flags) begin
                        r_d[AF_PI] = 1'b0;
                        r_d[AF_CI] = 1'b0;
                        r_d[AF_TI] = 1'b0;
                    end
                    if (set_pi) r_d[AF_PI] = 1'b1;
                end
            end else begin : g_plain
                // Plain read/write register.
                always_comb r_d = hit ? wdata : r_q;
            end

            // Register storage with per-index reset value.
            always_ff @(posedge clk) begin
                if (!rst_n) r_q <= ind_reset_val(g);
                else        r_q <= r_d;
            end

            assign bank_flat[g*REG_W +: REG_W] = r_q;
        end
    endgenerate

    assign fmt_q    = bank_flat[IX_FMT*REG_W +: REG_W];
    assign cfg_q    = bank_flat[IX_CFG*REG_W +: REG_W];
    assign ext_mode = bank_flat[IX_MODE*REG_W + MODE_EXT];
    assign afstat_w = bank_flat[IX_AFSTAT*REG_W +: REG_W];
    assign pmce     = afstat_w[AF_PMCE];

    // Detect a window write that drops the playback flag.
    always_comb begin
        pi_fall = win_wr && (idx == IDX_W'(IX_AFSTAT))
                  && afstat_w[AF_PI] && !wdata[AF_PI];
    end

    // Read selection with the calibration-busy overlay on register 11.
    always_comb begin
        rd_val = bank_flat[idx*REG_W +: REG_W];
        if (idx == IDX_W'(IX_ERRST)) begin
            rd_val = 8'h00;
            rd_val[ERR_CAL] = cal_busy;
        end
    end

endmodule

// File: rtl/codec_irq_ctrl.sv
// Module: interrupt status bit and acknowledge strobe.
// INT is set by a completion pulse and cleared by either acknowledge path.
// A set in the same cycle as a clear wins. The strobe marks a clear that
// found INT high.
module codec_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_int,
    input  logic clr_status,
    input  logic clr_flag,
    output logic int_q,
    output logic ack_q
);

    logic clr_any;

    assign clr_any = clr_status || clr_flag;

    // INT state: clear first, then set, so a new event is never lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
        end else if (set_int) begin
            int_q <= 1'b1;
        end else if (clr_any) begin
            int_q <= 1'b0;
        end
    end

    // Acknowledge strobe: one cycle after a clear of a pending interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= clr_any && int_q;
    end

endmodule

// File: rtl/codec_reg_if.sv
// Module: top of the codec host register interface.
// Decodes the 2-bit direct address, forms the indirect index from the pointer
// and the extended-mode bit, and muxes read data. Reads are combinational;
// read side effects happen at the edge while bus_rd is high.
// Assumes bus_rd and bus_wr are never high together.
module codec_reg_if
    import codec_reg_pkg::*;
#(
    parameter int unsigned REG_N    = 32,
    parameter int unsigned CAL_LOAD = 3,
    localparam int unsigned IDX_W   = $clog2(REG_N)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pb_done,
    output logic       irq,
    output logic       irq_ack,
    output logic [7:0] fmt_out,
    output logic [7:0] cfg_out
);

    logic [7:0]       ptr_q;
    logic             cal_busy;
    logic             ext_mode;
    logic             pmce_w;
    logic             pi_fall;
    logic [7:0]       ind_rd;
    logic [IDX_W-1:0] ind_idx;
    logic             ptr_wr, win_wr, stat_wr, win_rd;
    logic             int_q;

    // Direct address decode.
    always_comb begin
        ptr_wr  = bus_wr && (bus_addr == DR_PTR);
        win_wr  = bus_wr && (bus_addr == DR_WINDOW);
        stat_wr = bus_wr && (bus_addr == DR_STATUS);
        win_rd  = bus_rd && (bus_addr == DR_WINDOW);
    end

    // Indirect index: 4 bits normally, full width in extended mode.
    always_comb begin
        ind_idx = ptr_q[IDX_W-1:0];
        if (!ext_mode) ind_idx[IDX_W-1] = 1'b0;
    end

    codec_ptr_unit #(.CAL_LOAD(CAL_LOAD)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .wdata    (bus_wdata),
        .cal_en   (cfg_out[4:3] != 2'b00),
        .cal_take (win_rd && (ind_idx == IDX_W'(IX_ERRST))),
        .ptr_q    (ptr_q),
        .cal_busy (cal_busy)
    );

    codec_ind_bank #(.REG_N(REG_N)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_wr    (win_wr),
        .idx       (ind_idx),
        .wdata     (bus_wdata),
        .mce       (ptr_q[PTR_MCE]),
        .cal_busy  (cal_busy),
        .set_pi    (pb_done),
        .clr_flags (stat_wr),
        .rd_val    (ind_rd),
        .fmt_q     (fmt_out),
        .cfg_q     (cfg_out),
        .ext_mode  (ext_mode),
        .pmce      (pmce_w),
        .pi_fall   (pi_fall)
    );

    codec_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_int    (pb_done),
        .clr_status (stat_wr),
        .clr_flag   (pi_fall),
        .int_q      (int_q),
        .ack_q      (irq_ack)
    );

    assign irq = int_q;

    // Read data mux over the four direct registers.
    always_comb begin
        case (dreg_e'(bus_addr))
            DR_PTR:    bus_rdata = {1'b0, ptr_q[6:0]};
            DR_WINDOW: bus_rdata = ind_rd;
            DR_STATUS: bus_rdata = {7'b0, int_q};
            default:   bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/codec_reg_chk.sv
// Checker: temporal properties of the codec host register interface,
// attached to every instance of the top module with a bind.
module codec_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       pb_done,
    input logic       irq,
    input logic       irq_ack,
    input logic [7:0] fmt_out,
    input logic [7:0] cfg_out,
    input logic       mce,
    input logic       pmce,
    input logic [4:0] ind_idx
);

    logic fmt_wr;
    assign fmt_wr = bus_wr && (bus_addr == 2'd1) && (ind_idx == 5'd8);

    AST_STATUS_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !pb_done) |=> !irq); // R9

    AST_ACK_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> $past(irq)); // R9

    AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pb_done |=> irq); // R11

    AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_wr |=> $stable(fmt_out)); // R5

    AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_wr && !mce && !pmce) |=> $stable(fmt_out)); // R5

    AST_FMT_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_wr && !mce && pmce) |=> (fmt_out[3:0] == $past(fmt_out[3:0]))); // R5

    AST_CFG_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr) |-> !cfg_out[5]); // R6

endmodule

bind codec_reg_if codec_reg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .pb_done  (pb_done),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .fmt_out  (fmt_out),
    .cfg_out  (cfg_out),
    .mce      (ptr_q[6]),
    .pmce     (pmce_w),
    .ind_idx  (5'(ind_idx))
);

// File: tb/sim_codec_reg_if.sv
// Bench: a vector table walked by one loop, then directed interrupt,
// collision and calibration tests.
module sim_codec_reg_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pb_done = 1'b0;
    logic       irq, irq_ack;
    logic [7:0] fmt_out, cfg_out;

    int   n_chk = 0;
    int   n_err = 0;
    logic last_ack;
    logic [7:0] rv;

    always #4 clk = ~clk;   // 125 MHz

    codec_reg_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pb_done(pb_done), .irq(irq), .irq_ack(irq_ack),
        .fmt_out(fmt_out), .cfg_out(cfg_out)
    );

    // {op(0 wr,1 rd), addr, data, expected, requirement}
    localparam int NV = 49;
    localparam logic [23:0] VEC [NV] = '{
        {2'd1,2'd0,8'h00,8'h40,4'd2},   // R2 pointer reset
        {2'd1,2'd1,8'h00,8'h00,4'd4},   // R4 reg0
        {2'd0,2'd0,8'h82,8'h00,4'd2},   // R2 bit7 dropped
        {2'd1,2'd0,8'h00,8'h02,4'd2},   // R2
        {2'd1,2'd1,8'h00,8'h88,4'd4},   // R4 reg2
        {2'd0,2'd0,8'h06,8'h00,4'd4},
        {2'd1,2'd1,8'h00,8'h80,4'd4},   // R4 reg6
        {2'd0,2'd0,8'h09,8'h00,4'd4},
        {2'd1,2'd1,8'h00,8'h08,4'd4},   // R4 reg9
        {2'd0,2'd1,8'hFF,8'h00,4'd6},
        {2'd1,2'd1,8'h00,8'hDF,4'd6},   // R6 bit5 zero
        {2'd0,2'd0,8'h0C,8'h00,4'd4},
        {2'd1,2'd1,8'h00,8'h8A,4'd4},   // R4 reg12
        {2'd0,2'd1,8'h7F,8'h00,4'd8},
        {2'd1,2'd1,8'h00,8'hCA,4'd8},   // R8 only bit6
        {2'd0,2'd0,8'h19,8'h00,4'd3},
        {2'd1,2'd1,8'h00,8'hA0,4'd3},   // R3 reg25 reachable
        {2'd0,2'd0,8'h1A,8'h00,4'd4},
        {2'd1,2'd1,8'h00,8'hA0,4'd4},   // R4 reg26
        {2'd0,2'd0,8'h16,8'h00,4'd13},
        {2'd0,2'd1,8'h55,8'h00,4'd13},
        {2'd1,2'd1,8'h00,8'h00,4'd13},  // R13 reserved
        {2'd0,2'd0,8'h0B,8'h00,4'd7},
        {2'd0,2'd1,8'hFF,8'h00,4'd7},
        {2'd1,2'd1,8'h00,8'h00,4'd7},   // R7 read-only
        {2'd0,2'd0,8'h08,8'h00,4'd5},
        {2'd0,2'd1,8'h5A,8'h00,4'd5},
        {2'd1,2'd1,8'h00,8'h00,4'd5},   // R5 dropped
        {2'd0,2'd0,8'h48,8'h00,4'd12},  // R12 MCE rise, calibration on
        {2'd0,2'd1,8'h5A,8'h00,4'd5},
        {2'd1,2'd1,8'h00,8'h5A,4'd5},   // R5 full
        {2'd0,2'd0,8'h18,8'h00,4'd5},
        {2'd0,2'd1,8'h80,8'h00,4'd5},
        {2'd0,2'd0,8'h08,8'h00,4'd5},
        {2'd0,2'd1,8'hC3,8'h00,4'd5},
        {2'd1,2'd1,8'h00,8'hCA,4'd5},   // R5 partial
        {2'd0,2'd0,8'h0B,8'h00,4'd12},
        {2'd1,2'd1,8'h00,8'h20,4'd12},  // R12 busy 1
        {2'd1,2'd1,8'h00,8'h20,4'd12},  // R12 busy 2
        {2'd1,2'd1,8'h00,8'h20,4'd12},  // R12 busy 3
        {2'd1,2'd1,8'h00,8'h00,4'd12},  // R12 done
        {2'd0,2'd3,8'h77,8'h00,4'd1},
        {2'd1,2'd3,8'h00,8'h00,4'd1},   // R1 data port
        {2'd1,2'd2,8'h00,8'h00,4'd1},   // R1 status
        {2'd0,2'd0,8'h0C,8'h00,4'd8},
        {2'd0,2'd1,8'h00,8'h00,4'd8},
        {2'd1,2'd1,8'h00,8'h8A,4'd8},   // R8 bit6 cleared
        {2'd0,2'd0,8'h19,8'h00,4'd3},
        {2'd1,2'd1,8'h00,8'hDF,4'd3}    // R3 aliases to reg9
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1 last_ack = irq_ack;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        pb_done = 1'b1;
        @(negedge clk);
        pb_done = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R4 irq after reset", {7'b0, irq}, 8'h00);
        chk("R4 ack after reset", {7'b0, irq_ack}, 8'h00);
        chk("R4 fmt_out after reset", fmt_out, 8'h00);
        chk("R4 cfg_out after reset", cfg_out, 8'h08);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            v = VEC[i];
            if (v[23:22] == 2'd0) begin
                wr(v[21:20], v[19:12]);
            end else begin
                rd(v[21:20], rv);
                chk($sformatf("R%0d vector %0d", v[3:0], i), rv, v[11:4]);
            end
        end

        chk("R5 fmt_out port", fmt_out, 8'hCA);
        chk("R6 cfg_out port", cfg_out, 8'hDF);

        // Enter extended mode so register 24 is reachable.
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'h40);

        // R11: completion raises INT and the playback flag.
        pulse_done();
        chk("R11 irq set", {7'b0, irq}, 8'h01);
        rd(2'd2, rv);
        chk("R11 status INT", rv, 8'h01);
        wr(2'd0, 8'h18);
        rd(2'd1, rv);
        chk("R11 flag set", rv, 8'h90);

        // R9: status write acknowledges.
        wr(2'd2, 8'h00);
        chk("R9 irq cleared", {7'b0, irq}, 8'h00);
        chk("R9 ack strobe", {7'b0, last_ack}, 8'h01);
        rd(2'd1, rv);
        chk("R9 flags cleared", rv, 8'h80);

        // R10: dropping the playback flag acknowledges.
        pulse_done();
        wr(2'd1, 8'h80);
        chk("R10 irq cleared", {7'b0, irq}, 8'h00);
        chk("R10 ack strobe", {7'b0, last_ack}, 8'h01);
        rd(2'd2, rv);
        chk("R10 status INT", rv, 8'h00);

        // R11: completion and status write in the same cycle.
        pulse_done();
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h00; bus_wr = 1'b1; pb_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pb_done = 1'b0;
        #1 chk("R11 set wins irq", {7'b0, irq}, 8'h01);
        rd(2'd1, rv);
        chk("R11 set wins flag", rv, 8'h90);

        // R12: MCE rise without calibration enable loads nothing.
        wr(2'd0, 8'h09);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h4B);
        rd(2'd1, rv);
        chk("R12 no calibration", rv, 8'h00);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule